// File: doc/BRIEF.md
# Dual-Port Audio Interrupt and Reset Controller

This block is the shared control point for two audio ports, A and B. Each port has an output FIFO and an input FIFO, so there are four interrupt sources. Each FIFO request passes through an edge detector into a sticky pending bit. An edge-enable register selects which sources may latch. An output-enable register selects which pending bits drive the single CPU interrupt line.

The same register space also holds three other registers. A software reset register has active-low bits for the whole block, for the interrupt logic and for each port. A clock register has one enable bit per port. A read-only size register reports a 3-bit capacity code for each FIFO. Software clears a pending interrupt in one of two ways: it writes zero to that source's pending bit, or it pulses the interrupt-reset bit low and then high. The FIFOs and the serial logic sit outside the block. Their request lines and size codes arrive as inputs, and their resets and clock enables leave as outputs. The register bus is synchronous: a write takes effect at the clock edge, and read data follows the address combinationally.

Top module: `aud_irq_rst_ctrl`

## Requirements
- R1: The registers sit at these offsets: pending 0x1F4, edge enable 0x1F8, output enable 0x1FC, clock 0x210, software reset 0x214, size 0x218. Any other address reads zero. In the three interrupt registers, the sources sit at fixed bits: A output at bit 0, A input at bit 4, B output at bit 8, B input at bit 12.
- R2: After rst_ni is released, every register reads zero, both ports are held in reset, both clock enables are low and irq_o is low.
- R3: In the software reset register, bit 0 is the whole-block reset, bit 4 the interrupt reset, bit 8 the port A reset and bit 12 the port B reset. Each reset is active while its bit is 0. port_rst_no[0] is high only when bits 0 and 8 are both 1, and port_rst_no[1] is high only when bits 0 and 12 are both 1.
- R4: While bit 0 of the software reset register is 0, the edge-enable, output-enable, pending and clock registers read zero, writes to them are ignored, and irq_o stays low.
- R5: Bit 0 of the clock register drives port_clk_en_o[0] and bit 4 drives port_clk_en_o[1].
- R6: A pending bit sets at the first clock edge at which its request is sampled high after being sampled low, provided the source's edge-enable bit is 1. A request held high does not set the bit again, and a source whose edge-enable bit is 0 never sets.
- R7: irq_o is high exactly when some pending bit and the matching output-enable bit are both 1.
- R8: A write to the pending register clears each bit written as 0 and leaves each bit written as 1 unchanged. A rising edge latched in the same cycle wins over the clear.
- R9: While bit 4 of the software reset register is 0, all pending bits are cleared and held at zero, so writing that bit to 0 and then to 1 removes every pending interrupt.
- R10: The size register returns the 3-bit code of each source at that source's bit position (bits 2:0, 6:4, 10:8, 14:12) and ignores writes.
- R11: Every register bit that is not assigned to a source or a control bit reads zero and cannot be set by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write strobe, sampled at the clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| fifo_req_i | input | 4 | FIFO interrupt requests: [0] A out, [1] A in, [2] B out, [3] B in |
| fifo_size_i | input | 12 | Capacity codes, 3 bits per source, same order |
| irq_o | output | 1 | CPU interrupt line |
| port_rst_no | output | 2 | Active-low reset per port, [0] A, [1] B |
| port_clk_en_o | output | 2 | Clock enable per port, [0] A, [1] B |

## Verification
The bench goes after four kinds of fault. First, it holds a request high across a pending-bit clear: a design that latches on the level instead of the edge would set the bit again at once. Second, it makes a rising edge arrive in the same cycle as a zero write to the pending register: a design with the wrong priority would lose the interrupt. Third, it writes the masks and the clock register while the whole-block reset bit is low, and pulses a request while the interrupt reset is held: a design that leaks these would show stale masks, a running clock or a phantom pending bit. Fourth, it swaps the port reset bits and writes the size register: swapped bit positions or a writable size field would show up on the reset outputs and in the read data.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int unsigned FIELD_STRIDE = 4;

  localparam int unsigned OFF_PEND  = 32'h1F4;
  localparam int unsigned OFF_EDGE  = 32'h1F8;
  localparam int unsigned OFF_OUTEN = 32'h1FC;
  localparam int unsigned OFF_CLK   = 32'h210;
  localparam int unsigned OFF_SRST  = 32'h214;
  localparam int unsigned OFF_SIZE  = 32'h218;

  // software reset register field indices (bit = index * FIELD_STRIDE)
  localparam int unsigned SR_GLB   = 0;
  localparam int unsigned SR_IRQ   = 1;
  localparam int unsigned SR_PORT0 = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_EDGE,
    SEL_OUTEN,
    SEL_CLK,
    SEL_SRST,
    SEL_SIZE
  } reg_sel_e;
endpackage

// File: rtl/aud_irq_src.sv
module aud_irq_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic edge_en_i,
  input  logic hold_clr_i,
  input  logic wr_clr_i,
  output logic pend_o
);
  logic req_q;
  logic rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_i;
  end

  // reset hold dominates, then a new edge, then a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_o <= 1'b0;
    else if (hold_clr_i)        pend_o <= 1'b0;
    else if (rise && edge_en_i) pend_o <= 1'b1;
    else if (wr_clr_i)          pend_o <= 1'b0;
  end
endmodule

// File: rtl/aud_ctrl_regs.sv
module aud_ctrl_regs
  import aud_irq_pkg::*;
#(
  parameter int unsigned NUM_PORT = 2,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                srst_we_i,
  input  logic                clk_we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_PORT+1:0] srst_q_o,
  output logic                glob_n_o,
  output logic                irq_rst_n_o,
  output logic [NUM_PORT-1:0] port_rst_no,
  output logic [NUM_PORT-1:0] port_clk_en_o
);
  localparam int unsigned NUM_SR = NUM_PORT + 2;

  logic [NUM_SR-1:0]   srst_d;
  logic [NUM_PORT-1:0] clk_d;

  always_comb begin
    for (int k = 0; k < NUM_SR; k++) srst_d[k] = wdata_i[k*FIELD_STRIDE];
    for (int p = 0; p < NUM_PORT; p++) clk_d[p] = wdata_i[p*FIELD_STRIDE];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        srst_q_o <= '0;
    else if (srst_we_i) srst_q_o <= srst_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               port_clk_en_o <= '0;
    else if (!srst_q_o[SR_GLB]) port_clk_en_o <= '0;
    else if (clk_we_i)         port_clk_en_o <= clk_d;
  end

  assign glob_n_o    = srst_q_o[SR_GLB];
  assign irq_rst_n_o = srst_q_o[SR_IRQ];

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_port_rst
    assign port_rst_no[p] = srst_q_o[SR_GLB] & srst_q_o[SR_PORT0+p];
  end
endmodule

// File: rtl/aud_irq_rst_ctrl.sv
module aud_irq_rst_ctrl
  import aud_irq_pkg::*;
#(
  parameter int unsigned NUM_PORT = 2,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SIZE_W   = 3,
  localparam int unsigned NUM_SRC = 2 * NUM_PORT
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      we_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic [NUM_SRC-1:0]        fifo_req_i,
  input  logic [NUM_SRC*SIZE_W-1:0] fifo_size_i,
  output logic                      irq_o,
  output logic [NUM_PORT-1:0]       port_rst_no,
  output logic [NUM_PORT-1:0]       port_clk_en_o
);
  localparam int unsigned NUM_SR = NUM_PORT + 2;

  reg_sel_e            sel;
  logic [NUM_SRC-1:0]  edge_q, outen_q, pend_q, src_d;
  logic [NUM_SR-1:0]   srst_q;
  logic                glob_n, irq_rst_n;
  logic                wr_pend, wr_edge, wr_outen;

  always_comb begin
    sel = SEL_NONE;
    if      (addr_i == ADDR_W'(OFF_PEND))  sel = SEL_PEND;
    else if (addr_i == ADDR_W'(OFF_EDGE))  sel = SEL_EDGE;
    else if (addr_i == ADDR_W'(OFF_OUTEN)) sel = SEL_OUTEN;
    else if (addr_i == ADDR_W'(OFF_CLK))   sel = SEL_CLK;
    else if (addr_i == ADDR_W'(OFF_SRST))  sel = SEL_SRST;
    else if (addr_i == ADDR_W'(OFF_SIZE))  sel = SEL_SIZE;
  end

  assign wr_pend  = we_i && (sel == SEL_PEND);
  assign wr_edge  = we_i && (sel == SEL_EDGE);
  assign wr_outen = we_i && (sel == SEL_OUTEN);

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) src_d[i] = wdata_i[i*FIELD_STRIDE];
  end

  aud_ctrl_regs #(
    .NUM_PORT(NUM_PORT),
    .DATA_W  (DATA_W)
  ) i_ctrl_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .srst_we_i    (we_i && (sel == SEL_SRST)),
    .clk_we_i     (we_i && (sel == SEL_CLK)),
    .wdata_i      (wdata_i),
    .srst_q_o     (srst_q),
    .glob_n_o     (glob_n),
    .irq_rst_n_o  (irq_rst_n),
    .port_rst_no  (port_rst_no),
    .port_clk_en_o(port_clk_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q  <= '0;
      outen_q <= '0;
    end else if (!glob_n) begin
      edge_q  <= '0;
      outen_q <= '0;
    end else begin
      if (wr_edge)  edge_q  <= src_d;
      if (wr_outen) outen_q <= src_d;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    aud_irq_src i_src (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (fifo_req_i[i]),
      .edge_en_i (edge_q[i]),
      .hold_clr_i(~glob_n | ~irq_rst_n),
      .wr_clr_i  (wr_pend & ~src_d[i]),
      .pend_o    (pend_q[i])
    );
  end

  assign irq_o = |(pend_q & outen_q);

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_PEND:  for (int i = 0; i < NUM_SRC; i++) rdata_o[i*FIELD_STRIDE] = pend_q[i];
      SEL_EDGE:  for (int i = 0; i < NUM_SRC; i++) rdata_o[i*FIELD_STRIDE] = edge_q[i];
      SEL_OUTEN: for (int i = 0; i < NUM_SRC; i++) rdata_o[i*FIELD_STRIDE] = outen_q[i];
      SEL_CLK:   for (int p = 0; p < NUM_PORT; p++) rdata_o[p*FIELD_STRIDE] = port_clk_en_o[p];
      SEL_SRST:  for (int k = 0; k < NUM_SR; k++) rdata_o[k*FIELD_STRIDE] = srst_q[k];
      SEL_SIZE:  for (int i = 0; i < NUM_SRC; i++)
                   rdata_o[i*FIELD_STRIDE +: SIZE_W] = fifo_size_i[i*SIZE_W +: SIZE_W];
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/aud_irq_rst_ctrl_chk.sv
module aud_irq_rst_ctrl_chk #(
  parameter int unsigned NUM_PORT = 2,
  parameter int unsigned NUM_SRC  = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_SRC-1:0]  fifo_req_i,
  input logic                irq_o,
  input logic [NUM_PORT-1:0] port_rst_no,
  input logic [NUM_PORT-1:0] port_clk_en_o,
  input logic [NUM_SRC-1:0]  pend_q,
  input logic [NUM_SRC-1:0]  edge_q,
  input logic                glob_n,
  input logic                irq_rst_n
);
  logic [NUM_SRC-1:0] req_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_prev <= '0;
    else         req_prev <= fifo_req_i;
  end

  // R3: the whole-block reset forces every port reset
  a_r3_port_rst_follows_glb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_n |-> (port_rst_no == '0));

  // R4: no clocks and no interrupt while the block is held
  a_r4_clk_off_in_glb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_n |=> (port_clk_en_o == '0));

  a_r4_irq_quiet_in_glb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_n |=> !irq_o);

  // R9: interrupt reset leaves nothing pending
  a_r9_pend_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_rst_n |=> (pend_q == '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_chk
    // R6: an enabled rising edge always latches
    a_r6_edge_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (glob_n && irq_rst_n && edge_q[i] && fifo_req_i[i] && !req_prev[i]) |=> pend_q[i]);

    // R6: a source with its edge enable off never becomes pending
    a_r6_masked_stays_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!edge_q[i] && !pend_q[i]) |=> !pend_q[i]);
  end
endmodule

bind aud_irq_rst_ctrl aud_irq_rst_ctrl_chk #(
  .NUM_PORT(NUM_PORT),
  .NUM_SRC (NUM_SRC)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_req_i   (fifo_req_i),
  .irq_o        (irq_o),
  .port_rst_no  (port_rst_no),
  .port_clk_en_o(port_clk_en_o),
  .pend_q       (pend_q),
  .edge_q       (edge_q),
  .glob_n       (glob_n),
  .irq_rst_n    (irq_rst_n)
);

// File: tb/test_aud_irq_rst_ctrl.sv
module test_aud_irq_rst_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  fifo_req_i = '0;
  logic [11:0] fifo_size_i = '0;
  logic        irq_o;
  logic [1:0]  port_rst_no;
  logic [1:0]  port_clk_en_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  aud_irq_rst_ctrl i_aud_irq_rst_ctrl (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .fifo_req_i, .fifo_size_i, .irq_o, .port_rst_no, .port_clk_en_o
  );

  // reference model, register images kept in their bus layout
  logic [31:0] m_srst, m_clk, m_edge, m_outen, m_pend;
  logic [3:0]  m_req;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_srst = 0; m_clk = 0; m_edge = 0; m_outen = 0; m_pend = 0; m_req = 0;
    end else begin
      logic glb, irr;
      glb = m_srst[0];
      irr = m_srst[4];
      for (int i = 0; i < 4; i++) begin
        if (!glb || !irr) m_pend[4*i] = 1'b0;
        else if (fifo_req_i[i] && !m_req[i] && m_edge[4*i]) m_pend[4*i] = 1'b1;
        else if (we_i && addr_i == 12'h1F4 && !wdata_i[4*i]) m_pend[4*i] = 1'b0;
      end
      if (!glb) begin
        m_edge = 0; m_outen = 0; m_clk = 0;
      end else if (we_i) begin
        if (addr_i == 12'h1F8) m_edge  = wdata_i & 32'h1111;
        if (addr_i == 12'h1FC) m_outen = wdata_i & 32'h1111;
        if (addr_i == 12'h210) m_clk   = wdata_i & 32'h0011;
      end
      if (we_i && addr_i == 12'h214) m_srst = wdata_i & 32'h1111;
      m_req = fifo_req_i;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [31:0] s;
    s = 0;
    for (int i = 0; i < 4; i++) s[4*i +: 3] = fifo_size_i[3*i +: 3];
    case (a)
      12'h1F4: return m_pend;
      12'h1F8: return m_edge;
      12'h1FC: return m_outen;
      12'h210: return m_clk;
      12'h214: return m_srst;
      12'h218: return s;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk(32'(irq_o), 32'(|(m_pend & m_outen)), "R7 irq vs model");
    chk(32'(port_rst_no), 32'({m_srst[0] & m_srst[12], m_srst[0] & m_srst[8]}), "R3 port resets vs model");
    chk(32'(port_clk_en_o), 32'({m_clk[4], m_clk[0]}), "R5 clock enables vs model");
    chk(rdata_o, exp_rd(addr_i), "R1 read data vs model");
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
    if (rst_ni) cmp_model();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    cyc();
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    addr_i = a;
    cyc();
    chk(rdata_o, exp, tag);
  endtask

  task automatic pulse(input int src);
    fifo_req_i[src] = 1'b1;
    cyc();
    fifo_req_i[src] = 1'b0;
    cyc();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cyc();
    // R2 reset state
    chk(32'(port_rst_no), 32'h0, "R2 ports held in reset");
    chk(32'(port_clk_en_o), 32'h0, "R2 clocks off");
    chk(32'(irq_o), 32'h0, "R2 irq low");
    rd(12'h214, 32'h0, "R2 reset register");
    rd(12'h1F4, 32'h0, "R2 pending register");

    // R4 writes ignored while block held
    wr(12'h1F8, 32'hFFFF);
    rd(12'h1F8, 32'h0, "R4 edge enable held");
    wr(12'h210, 32'h11);
    chk(32'(port_clk_en_o), 32'h0, "R4 clock held off");

    // R3 / R11 release
    wr(12'h214, 32'hFFFF_FFFF);
    rd(12'h214, 32'h1111, "R11 reset register unused bits");
    chk(32'(port_rst_no), 32'h3, "R3 both ports released");

    // R5 clock bits
    wr(12'h210, 32'h10);
    chk(32'(port_clk_en_o), 32'h2, "R5 only port B clock");
    wr(12'h210, 32'h11);
    chk(32'(port_clk_en_o), 32'h3, "R5 both clocks");

    // R3 per-port reset bits
    wr(12'h214, 32'h0111);
    chk(32'(port_rst_no), 32'h1, "R3 port B reset bit 12");
    wr(12'h214, 32'h1011);
    chk(32'(port_rst_no), 32'h2, "R3 port A reset bit 8");
    wr(12'h214, 32'h1111);

    // R6 / R7 latch and gating
    wr(12'h1F8, 32'h1111);
    wr(12'h1FC, 32'h0001);
    pulse(1);
    rd(12'h1F4, 32'h0010, "R6 A input latched at bit 4");
    chk(32'(irq_o), 32'h0, "R7 unenabled source no irq");
    fifo_req_i[0] = 1'b1;
    cyc(); cyc();
    rd(12'h1F4, 32'h0011, "R6 A output latched at bit 0");
    chk(32'(irq_o), 32'h1, "R7 enabled source raises irq");
    wr(12'h1F4, 32'h0010);
    rd(12'h1F4, 32'h0010, "R8 zero write clears, held level no relatch");
    chk(32'(irq_o), 32'h0, "R6 level does not relatch");
    fifo_req_i[0] = 1'b0;
    cyc();

    // R8 same-cycle edge beats the clear
    fifo_req_i[2] = 1'b1;
    wr(12'h1F4, 32'h0);
    fifo_req_i[2] = 1'b0;
    rd(12'h1F4, 32'h0100, "R8 edge wins over clear");

    // R9 interrupt reset pulse
    wr(12'h214, 32'h1101);
    pulse(3);
    rd(12'h1F4, 32'h0, "R9 pending held clear");
    wr(12'h214, 32'h1111);
    rd(12'h1F4, 32'h0, "R9 nothing pending after pulse");

    // R6 edge enable off
    wr(12'h1F8, 32'h0111);
    pulse(3);
    rd(12'h1F4, 32'h0, "R6 disabled source never latches");
    pulse(2);
    rd(12'h1F4, 32'h0100, "R6 B output latched at bit 8");
    wr(12'h1FC, 32'h0100);
    chk(32'(irq_o), 32'h1, "R7 B output raises irq");

    // R10 size register
    fifo_size_i = {3'd5, 3'd2, 3'd7, 3'd1};
    rd(12'h218, 32'h5271, "R10 size codes");
    wr(12'h218, 32'h0);
    rd(12'h218, 32'h5271, "R10 size write ignored");

    // R1 / R11
    rd(12'h200, 32'h0, "R1 unmapped address");
    rd(12'h1F0, 32'h0, "R1 unmapped address below");
    wr(12'h1FC, 32'hFFFF_FFFF);
    rd(12'h1FC, 32'h1111, "R11 output enable unused bits");

    // R4 block reset again
    wr(12'h214, 32'h1110);
    rd(12'h1F4, 32'h0, "R4 pending cleared");
    rd(12'h1F8, 32'h0, "R4 edge enable cleared");
    rd(12'h1FC, 32'h0, "R4 output enable cleared");
    chk(32'(irq_o), 32'h0, "R4 irq low");
    chk(32'(port_clk_en_o), 32'h0, "R4 clocks off");
    chk(32'(port_rst_no), 32'h0, "R3 ports reset by bit 0");
    rd(12'h214, 32'h1110, "R3 reset register readback");
    summary();
  end
endmodule